// File: doc/BRIEF.md
# Word-Access GPIO Register Block

This block is a 32-line general-purpose I/O controller that sits on a simple single-cycle register bus. It keeps a pin-level register, a direction register and a spare auxiliary register. Software reads the levels and the direction, and writes the direction. Output levels are changed by writing a mask to a set strobe address or to a clear strobe address. The level register drives `pin_level` at all times. The direction register drives `pin_oe`, where a 1 means the line is an output.

A set or clear write is taken only when its mask overlaps at least one line that is configured as an output. Once a write is taken, the whole mask is applied, and that includes lines configured as inputs. A rejected strobe leaves the levels as they were and raises a write-to-input pulse. The three edge-detect addresses accept writes and change nothing. Any other address raises a bad-read or bad-write pulse, and so does an address that is not word aligned.

Each request passes through a decoder that sorts it into an access state. The states are `ACC_NONE`, `ACC_RD_LEVEL`, `ACC_RD_DIR`, `ACC_RD_AUX`, `ACC_RD_BAD`, `ACC_WR_DIR`, `ACC_WR_SET`, `ACC_WR_CLR`, `ACC_WR_AUX`, `ACC_WR_EDGE`, `ACC_WR_BAD` and `ACC_WR_REJ`. On every clock the response state register loads the decoded state. There is one exception: a set or clear strobe with no output overlap moves to `ACC_WR_REJ` in place of `ACC_WR_SET` or `ACC_WR_CLR`. With no request the register returns to `ACC_NONE`. The error outputs are decoded from this register, so each error is a pulse exactly one cycle long, in the cycle after the request.

Top module: `gpio_regblk`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pin_level`, `pin_oe`, `rsp_rdata` and all three error outputs are zero.
- R2: A read request at byte offset 0x00 returns the level register, at 0x04 returns the direction register, and at 0x20 returns the auxiliary register. The data appears on `rsp_rdata` in the cycle after the request.
- R3: A write to 0x04 loads the direction register, and the new value is seen on `pin_oe` in the next cycle. A write to 0x20 loads the auxiliary register.
- R4: A write to 0x08 whose data has at least one bit in common with the direction register ORs the full written word into the level register. Bits of input lines are included.
- R5: A write to 0x0C that passes the same overlap test clears every written bit in the level register, including bits of input lines.
- R6: A set or clear write whose data shares no bit with the direction register leaves the level register unchanged. It also pulses `err_wr_input` high for exactly one cycle, the cycle after the request.
- R7: Writes to 0x10, 0x14 and 0x18 change no register and raise no error.
- R8: A read at any address other than 0x00, 0x04 or 0x20 returns zero and pulses `err_bad_rd` for one cycle. This includes addresses whose two low bits are not zero.
- R9: A write at an unmapped or misaligned address changes no register and pulses `err_bad_wr` for one cycle.
- R10: While `req_valid` is low, the registers hold their values, all error outputs are low, and `rsp_rdata` is zero one cycle later. The same zero applies after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid one cycle after a read |
| pin_level | output | 32 | Level register |
| pin_oe | output | 32 | Direction register, 1 = output |
| err_bad_rd | output | 1 | One-cycle pulse after a read at an unmapped address |
| err_bad_wr | output | 1 | One-cycle pulse after a write at an unmapped address |
| err_wr_input | output | 1 | One-cycle pulse after a rejected set or clear |

## Verification
The hardest case to reach is a strobe whose mask spans both output lines and input lines. The bench programs a narrow direction value first. It then issues set and clear masks that touch one output bit together with many input bits, to show that the whole mask is applied. It also issues masks that touch only input bits, to show that they are rejected. Direction is then cleared to zero and an all-ones set is sent, so every line is an input and the strobe must be rejected. Back-to-back requests, and idle cycles with the other bus inputs toggling, confirm that the error outputs are single-cycle pulses.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;

    localparam int unsigned DATA_W = 32;

    localparam int unsigned OFS_LEVEL = 32'h00;
    localparam int unsigned OFS_DIR   = 32'h04;
    localparam int unsigned OFS_SET   = 32'h08;
    localparam int unsigned OFS_CLR   = 32'h0C;
    localparam int unsigned OFS_RISE  = 32'h10;
    localparam int unsigned OFS_FALL  = 32'h14;
    localparam int unsigned OFS_EDGE  = 32'h18;
    localparam int unsigned OFS_AUX   = 32'h20;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_RD_LEVEL,
        ACC_RD_DIR,
        ACC_RD_AUX,
        ACC_RD_BAD,
        ACC_WR_DIR,
        ACC_WR_SET,
        ACC_WR_CLR,
        ACC_WR_AUX,
        ACC_WR_EDGE,
        ACC_WR_BAD,
        ACC_WR_REJ
    } acc_kind_e;

endpackage

// File: rtl/gpio_acc_decode.sv
module gpio_acc_decode
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);
    localparam int unsigned LSB_W = 2;

    logic        aligned;
    logic [31:0] ofs;

    always_comb begin
        aligned = (addr[LSB_W-1:0] == '0);
        ofs     = 32'(addr);
        kind    = ACC_NONE;
        if (valid) begin
            if (!aligned) begin
                kind = write ? ACC_WR_BAD : ACC_RD_BAD;
            end else if (write) begin
                unique case (ofs)
                    OFS_DIR:                      kind = ACC_WR_DIR;
                    OFS_SET:                      kind = ACC_WR_SET;
                    OFS_CLR:                      kind = ACC_WR_CLR;
                    OFS_RISE, OFS_FALL, OFS_EDGE: kind = ACC_WR_EDGE;
                    OFS_AUX:                      kind = ACC_WR_AUX;
                    default:                      kind = ACC_WR_BAD;
                endcase
            end else begin
                unique case (ofs)
                    OFS_LEVEL: kind = ACC_RD_LEVEL;
                    OFS_DIR:   kind = ACC_RD_DIR;
                    OFS_AUX:   kind = ACC_RD_AUX;
                    default:   kind = ACC_RD_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        kind,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] aux_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            aux_q <= '0;
        end else begin
            if (kind == ACC_WR_DIR) dir_q <= wdata;
            if (kind == ACC_WR_AUX) aux_q <= wdata;
        end
    end

    assert_edge_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_EDGE || kind == ACC_WR_BAD) |=> ($stable(dir_q) && $stable(aux_q)));

    assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_DIR) |=> (dir_q == $past(wdata)));

endmodule

// File: rtl/gpio_level_ctrl.sv
module gpio_level_ctrl
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_kind_e        kind,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] dir,
    output logic             overlap,
    output logic [WIDTH-1:0] level_q
);

    always_comb overlap = |(dir & wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (overlap) begin
            if (kind == ACC_WR_SET)      level_q <= level_q | wdata;
            else if (kind == ACC_WR_CLR) level_q <= level_q & ~wdata;
        end
    end

    assert_set_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_SET && overlap) |=> (level_q == ($past(level_q) | $past(wdata))));

    assert_clr_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_CLR && overlap) |=> (level_q == ($past(level_q) & ~$past(wdata))));

    assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == ACC_WR_SET || kind == ACC_WR_CLR) && !overlap) |=> $stable(level_q));

endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WIDTH  = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WIDTH-1:0]  req_wdata,
    output logic [WIDTH-1:0]  rsp_rdata,
    output logic [WIDTH-1:0]  pin_level,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              err_bad_rd,
    output logic              err_bad_wr,
    output logic              err_wr_input
);

    acc_kind_e        kind;
    acc_kind_e        st_q;
    acc_kind_e        st_d;
    logic             overlap;
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] aux_q;
    logic [WIDTH-1:0] rdata_q;

    gpio_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .kind  (kind)
    );

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .wdata (req_wdata),
        .dir_q (dir_q),
        .aux_q (aux_q)
    );

    gpio_level_ctrl #(.WIDTH(WIDTH)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .wdata   (req_wdata),
        .dir     (dir_q),
        .overlap (overlap),
        .level_q (level_q)
    );

    // Next response state: rejected strobes are renamed here.
    always_comb begin
        st_d = kind;
        if ((kind == ACC_WR_SET || kind == ACC_WR_CLR) && !overlap) st_d = ACC_WR_REJ;
    end

    // State register and registered read data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ACC_NONE;
            rdata_q <= '0;
        end else begin
            st_q <= st_d;
            unique case (kind)
                ACC_RD_LEVEL: rdata_q <= level_q;
                ACC_RD_DIR:   rdata_q <= dir_q;
                ACC_RD_AUX:   rdata_q <= aux_q;
                default:      rdata_q <= '0;
            endcase
        end
    end

    // Outputs decoded from the response state.
    always_comb begin
        rsp_rdata    = rdata_q;
        pin_level    = level_q;
        pin_oe       = dir_q;
        err_bad_rd   = 1'b0;
        err_bad_wr   = 1'b0;
        err_wr_input = 1'b0;
        unique case (st_q)
            ACC_RD_BAD: err_bad_rd   = 1'b1;
            ACC_WR_BAD: err_bad_wr   = 1'b1;
            ACC_WR_REJ: err_wr_input = 1'b1;
            default: ;
        endcase
    end

    assert_err_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_bad_rd, err_bad_wr, err_wr_input}));

    assert_bad_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_bad_rd |-> (rsp_rdata == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(pin_level) && $stable(pin_oe) && rsp_rdata == '0
                        && !err_bad_rd && !err_bad_wr && !err_wr_input));

endmodule

// File: tb/gpio_regblk_bench.sv
module gpio_regblk_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata, pin_level, pin_oe;
    logic        err_bad_rd, err_bad_wr, err_wr_input;

    always #2 clk = ~clk;

    gpio_regblk u_gpio_regblk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .pin_level(pin_level), .pin_oe(pin_oe), .err_bad_rd(err_bad_rd),
        .err_bad_wr(err_bad_wr), .err_wr_input(err_wr_input)
    );

    typedef struct {
        int          due;
        string       tag;
        logic [31:0] rd;
        logic [31:0] lvl;
        logic [31:0] oe;
        logic [2:0]  err;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] m_lvl = '0, m_dir = '0, m_aux = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare results that are due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic [2:0] got_err;
            e = sb.pop_front();
            got_err = {err_bad_rd, err_bad_wr, err_wr_input};
            n_cmp++;
            if (rsp_rdata !== e.rd || pin_level !== e.lvl || pin_oe !== e.oe || got_err !== e.err) begin
                n_bad++;
                $display("FAIL %s: rd=%h lvl=%h oe=%h err=%b expected rd=%h lvl=%h oe=%h err=%b",
                         e.tag, rsp_rdata, pin_level, pin_oe, got_err, e.rd, e.lvl, e.oe, e.err);
            end
        end
    end

    task automatic push(input string tag, input logic [31:0] rd, input logic [2:0] err);
        exp_t e;
        e.due = cyc + 1; e.tag = tag; e.rd = rd;
        e.lvl = m_lvl; e.oe = m_dir; e.err = err;
        sb.push_back(e);
    endtask

    task automatic do_rd(input logic [7:0] a, input string tag);
        logic [31:0] rd;
        logic [2:0]  err;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 32'hA5A5_5A5A;
        err = 3'b000;
        case (a)
            8'h00:   rd = m_lvl;
            8'h04:   rd = m_dir;
            8'h20:   rd = m_aux;
            default: begin rd = '0; err = 3'b100; end
        endcase
        push(tag, rd, err);
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [2:0] err;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        err = 3'b000;
        case (a)
            8'h04: m_dir = d;
            8'h20: m_aux = d;
            8'h08: if ((m_dir & d) != 0) m_lvl = m_lvl | d; else err = 3'b001;
            8'h0C: if ((m_dir & d) != 0) m_lvl = m_lvl & ~d; else err = 3'b001;
            8'h10, 8'h14, 8'h18: ;
            default: err = 3'b010;
        endcase
        push(tag, '0, err);
    endtask

    task automatic do_idle(input logic [7:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = d[0]; req_addr = a; req_wdata = d;
        push(tag, '0, 3'b000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if ({rsp_rdata, pin_level, pin_oe} !== '0 || {err_bad_rd, err_bad_wr, err_wr_input} !== 3'b000) begin
            n_bad++;
            $display("FAIL R1 in reset: rd=%h lvl=%h oe=%h expected all zero", rsp_rdata, pin_level, pin_oe);
        end
        rst_n = 1'b1;
        do_idle(8'h00, 32'h0, "R1 after reset");
        do_rd(8'h00, "R2 level reset");
        do_rd(8'h04, "R2 dir reset");
        do_rd(8'h20, "R2 aux reset");
        do_wr(8'h04, 32'h0000_00FF, "R3 dir write");
        do_rd(8'h04, "R2 dir readback");
        do_wr(8'h20, 32'hDEAD_BEEF, "R3 aux write");
        do_rd(8'h20, "R2 aux readback");
        do_wr(8'h08, 32'h0000_0F0F, "R4 set outputs and inputs");
        do_wr(8'h08, 32'hFF00_0001, "R4 set full mask with one output bit");
        do_rd(8'h00, "R2 level after set");
        do_wr(8'h08, 32'h0F00_0000, "R6 set on inputs only");
        do_idle(8'h08, 32'hFFFF_FFFF, "R6 pulse ends");
        do_wr(8'h0C, 32'h0000_0003, "R5 clear outputs");
        do_wr(8'h0C, 32'hFF00_0100, "R6 clear on inputs only");
        do_wr(8'h0C, 32'hF000_0004, "R5 clear full mask with one output bit");
        do_rd(8'h00, "R2 level after clear");
        do_wr(8'h10, 32'hFFFF_FFFF, "R7 rising edge write");
        do_wr(8'h14, 32'hFFFF_FFFF, "R7 falling edge write");
        do_wr(8'h18, 32'h1234_5678, "R7 edge status write");
        do_rd(8'h00, "R7 level unchanged");
        do_rd(8'h10, "R8 read edge address");
        do_rd(8'h08, "R8 read set strobe");
        do_rd(8'h02, "R8 misaligned read");
        do_rd(8'hFC, "R8 high unmapped read");
        do_wr(8'h00, 32'hFFFF_FFFF, "R9 write level address");
        do_wr(8'h06, 32'hFFFF_FFFF, "R9 misaligned write");
        do_wr(8'h24, 32'h0000_0001, "R9 unmapped write");
        do_rd(8'h20, "R9 aux unchanged");
        do_idle(8'h04, 32'hFFFF_FFFF, "R10 idle with dir address");
        do_idle(8'h08, 32'hFFFF_FFFF, "R10 idle with set address");
        do_wr(8'h04, 32'h0000_0000, "R3 dir cleared");
        do_wr(8'h08, 32'hFFFF_FFFF, "R6 all inputs set rejected");
        do_wr(8'h04, 32'h8000_0000, "R3 dir top bit");
        do_wr(8'h08, 32'h8000_00F0, "R4 set via top output");
        do_rd(8'h00, "R2 final level");
        do_idle(8'h00, 32'h0, "R10 final idle");
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule